// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level table held in ordinary memory. For each request it reads one directory word and then one table word through a single-word memory port. It checks the present and writable flags on each word it reads. On a write access whose page has not yet been marked modified, it also writes the final word back with the modified flag set.

A request is presented while `ready` is high. It carries the address, a write flag and the frame number of the directory. The walker answers with a one-cycle `done` pulse. Together with that pulse it gives either a physical address, or a fault flag with a two-bit cause. Caching of translations, large pages and fault recovery are left to other blocks.

Every table word uses one layout:

| Bits | Meaning |
|---|---|
| 31:12 | frame number |
| 0 | present |
| 1 | writable |
| 6 | modified |
| all others | ignored |

Top module: `pt_walker`

## Requirements
- R1: The first read goes to byte address `{dir_root, 12'b0} + 4*vaddr[31:22]`, and `mem_addr` holds steady while a read waits for `mem_ack`.
- R2: The second read goes to byte address `{dir_frame, 12'b0} + 4*vaddr[21:12]`, where `dir_frame` is bits 31:12 of the directory word.
- R3: A successful walk returns `paddr = {table_word[31:12], vaddr[11:0]}` with `fault` low and `fault_cause` 0.
- R4: A directory word with bit 0 clear gives `fault` high and `fault_cause` 1, with no second read.
- R5: A table word with bit 0 clear gives `fault` high and `fault_cause` 2.
- R6: A write access gives `fault_cause` 3 when the word being checked is present but has bit 1 clear. This check applies at either level, and nothing is written back.
- R7: A successful write whose table word has bit 6 clear writes that word back, with bit 6 set, to the address it was read from, before `done`. No write happens for reads, for faults, or when bit 6 is already set.
- R8: After reset `ready` is 1 and `done`, `fault` and `mem_req` are 0.
- R9: A request is taken only while `ready` is high. `req_valid` while busy is ignored. `done` lasts one cycle per accepted request.
- R10: With a memory that acknowledges one cycle after a request, `done` appears at these clock edges after the accepting edge: 2 for a fault at the directory, 4 for any other walk without write-back, and 6 with write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | translation request |
| req_write | input | 1 | 1 for a write access |
| req_vaddr | input | 32 | virtual address |
| dir_root | input | 20 | frame number of the directory |
| ready | output | 1 | walker idle, request may be given |
| done | output | 1 | one-cycle result strobe |
| fault | output | 1 | translation failed (valid with done) |
| fault_cause | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 write protected |
| paddr | output | 32 | physical address (valid with done, no fault) |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | memory access is a write |
| mem_addr | output | 32 | byte address of the word |
| mem_wdata | output | 32 | word to write |
| mem_ack | input | 1 | access complete, read data valid |
| mem_rdata | input | 32 | read data |

## Verification
The memory model in the bench raises `mem_ack` one cycle after it sees a request, so each access costs two clock edges. After a request is accepted, a directory fault is therefore due on edge 2, a full walk on edge 4, and a walk with write-back on edge 6. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the accepting edge up to `done`, and compares that count with the expected number for each scenario. It checks address, fault and memory contents in that same sampling slot. For ignored requests it watches a window after the pulse for any further `done`.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = VA_W - OFF_W;
  localparam int unsigned SLOT_LG = 2;

  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITABLE = 1;
  localparam int unsigned BIT_DIRTY    = 6;

  typedef enum logic [1:0] {
    CAUSE_NONE       = 2'd0,
    CAUSE_DIR_ABSENT = 2'd1,
    CAUSE_TBL_ABSENT = 2'd2,
    CAUSE_WPROT      = 2'd3
  } cause_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_TBL, ST_WB, ST_DONE
  } walk_st_t;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               present;
    logic               writable;
    logic               dirty;
  } entry_view_t;

  function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input logic [VA_W-1:0] va);
    return va[OFF_W+IDX_W-1 -: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [FRAME_W-1:0] base,
                                                input logic [IDX_W-1:0]   idx);
    logic [VA_W-1:0] wide_idx;
    wide_idx = VA_W'(idx);
    return {base, {OFF_W{1'b0}}} | (wide_idx << SLOT_LG);
  endfunction

  function automatic logic [VA_W-1:0] join_paddr(input logic [FRAME_W-1:0] frame,
                                                 input logic [VA_W-1:0]    va);
    return {frame, va[OFF_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] mark_dirty(input logic [VA_W-1:0] word);
    logic [VA_W-1:0] out;
    out = word;
    out[BIT_DIRTY] = 1'b1;
    return out;
  endfunction
endpackage

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] entry,
  input  logic            is_write,
  input  logic            level_tbl,
  output entry_view_t     view,
  output cause_t          cause,
  output logic            need_wb
);
  logic unused_rsvd;
  assign unused_rsvd = ^{entry[OFF_W-1:BIT_DIRTY+1], entry[BIT_DIRTY-1:BIT_WRITABLE+1]};

  always_comb begin
    view.frame    = entry[VA_W-1:OFF_W];
    view.present  = entry[BIT_PRESENT];
    view.writable = entry[BIT_WRITABLE];
    view.dirty    = entry[BIT_DIRTY];
  end

  always_comb begin
    cause = CAUSE_NONE;
    if (!view.present)
      cause = level_tbl ? CAUSE_TBL_ABSENT : CAUSE_DIR_ABSENT;
    else if (is_write && !view.writable)
      cause = CAUSE_WPROT;
  end

  assign need_wb = level_tbl && is_write && (cause == CAUSE_NONE) && !view.dirty;

  // R6: a protection fault only ever arises for a write access
  always_comb begin
    if (cause == CAUSE_WPROT)
      assert (is_write) else $error("p_wprot_write_only_r6");
  end
endmodule

// File: rtl/pt_port_drive.sv
module pt_port_drive
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  walk_st_t           st,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [FRAME_W-1:0] root,
  input  logic [FRAME_W-1:0] tbl_base,
  input  logic [VA_W-1:0]    wb_word,
  input  logic               mem_ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata
);
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_DIR: begin
        mem_req  = 1'b1;
        mem_addr = slot_addr(root, dir_index(vaddr));
      end
      ST_TBL: begin
        mem_req  = 1'b1;
        mem_addr = slot_addr(tbl_base, tbl_index(vaddr));
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_addr(tbl_base, tbl_index(vaddr));
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  p_hold_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_DIRTY] && mem_wdata[BIT_PRESENT] && mem_wdata[BIT_WRITABLE]);

  p_wb_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_ack) && $past(mem_req) && !$past(mem_we));
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [FRAME_W-1:0] dir_root,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata,
  input  entry_view_t        ev_view,
  input  cause_t             ev_cause,
  input  logic               ev_need_wb,
  output walk_st_t           st,
  output logic               wr_q,
  output logic [VA_W-1:0]    vaddr_q,
  output logic [FRAME_W-1:0] root_q,
  output logic [FRAME_W-1:0] tbl_base_q,
  output logic [VA_W-1:0]    wb_q,
  output logic               fault_q,
  output cause_t             cause_q,
  output logic [VA_W-1:0]    paddr_q
);
  logic accept, leaf_ok;
  assign accept  = (st == ST_IDLE) && req_valid;
  assign leaf_ok = (st == ST_TBL) && mem_ack && (ev_cause == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      wr_q       <= 1'b0;
      vaddr_q    <= '0;
      root_q     <= '0;
      tbl_base_q <= '0;
      wb_q       <= '0;
      fault_q    <= 1'b0;
      cause_q    <= CAUSE_NONE;
      paddr_q    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          vaddr_q <= req_vaddr;
          wr_q    <= req_write;
          root_q  <= dir_root;
          fault_q <= 1'b0;
          cause_q <= CAUSE_NONE;
          paddr_q <= '0;
          st      <= ST_DIR;
        end
        ST_DIR: if (mem_ack) begin
          if (ev_cause != CAUSE_NONE) begin
            fault_q <= 1'b1;
            cause_q <= ev_cause;
            st      <= ST_DONE;
          end else begin
            tbl_base_q <= ev_view.frame;
            st         <= ST_TBL;
          end
        end
        ST_TBL: if (mem_ack) begin
          if (ev_cause != CAUSE_NONE) begin
            fault_q <= 1'b1;
            cause_q <= ev_cause;
            st      <= ST_DONE;
          end else begin
            paddr_q <= join_paddr(ev_view.frame, vaddr_q);
            if (ev_need_wb) begin
              wb_q <= mark_dirty(mem_rdata);
              st   <= ST_WB;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_WB:   if (mem_ack) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_paddr_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) && !fault_q |-> paddr_q[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

  p_cause_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> fault_q == (cause_q != CAUSE_NONE));

  p_leaf_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_ok |=> !fault_q && (paddr_q[VA_W-1:OFF_W] == $past(mem_rdata[VA_W-1:OFF_W])));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [FRAME_W-1:0] dir_root,
  output logic               ready,
  output logic               done,
  output logic               fault,
  output logic [1:0]         fault_cause,
  output logic [VA_W-1:0]    paddr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata
);
  walk_st_t           st;
  logic               wr_q;
  logic [VA_W-1:0]    vaddr_q, wb_q, paddr_q;
  logic [FRAME_W-1:0] root_q, tbl_base_q;
  logic               fault_q;
  cause_t             cause_q;
  entry_view_t        ev_view;
  cause_t             ev_cause;
  logic               ev_need_wb;

  pt_entry_eval u_eval (
    .entry     (mem_rdata),
    .is_write  (wr_q),
    .level_tbl (st == ST_TBL),
    .view      (ev_view),
    .cause     (ev_cause),
    .need_wb   (ev_need_wb)
  );

  pt_walk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_vaddr  (req_vaddr),
    .dir_root   (dir_root),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .ev_view    (ev_view),
    .ev_cause   (ev_cause),
    .ev_need_wb (ev_need_wb),
    .st         (st),
    .wr_q       (wr_q),
    .vaddr_q    (vaddr_q),
    .root_q     (root_q),
    .tbl_base_q (tbl_base_q),
    .wb_q       (wb_q),
    .fault_q    (fault_q),
    .cause_q    (cause_q),
    .paddr_q    (paddr_q)
  );

  pt_port_drive u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .vaddr     (vaddr_q),
    .root      (root_q),
    .tbl_base  (tbl_base_q),
    .wb_word   (wb_q),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign ready       = (st == ST_IDLE);
  assign done        = (st == ST_DONE);
  assign fault       = fault_q;
  assign fault_cause = cause_q;
  assign paddr       = paddr_q;

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req && !done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && ready);

  p_no_wb_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !fault);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] dir_root = '0;
  logic        ready, done, fault;
  logic [1:0]  fault_cause;
  logic [31:0] paddr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:4095];
  logic        ld_en = 1'b0;
  logic [31:0] ld_addr = '0, ld_data = '0;
  int          wr_count;
  logic [31:0] last_wa;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .dir_root(dir_root), .ready(ready), .done(done),
    .fault(fault), .fault_cause(fault_cause), .paddr(paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr[13:2]] <= ld_data;
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      wr_count <= 0;
      last_wa  <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_req && mem_we && !mem_ack) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_count <= wr_count + 1;
        last_wa  <= mem_addr;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic wr, input logic [19:0] root,
                         output int lat, output logic [31:0] pa, output logic f, output logic [1:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; dir_root = root;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end while (!done && lat < 30);
    pa = paddr; f = fault; c = fault_cause;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ready == 1'b1, "R8 ready", 32'(ready), 1);
    check(done == 1'b0 && fault == 1'b0, "R8 done/fault", {30'b0, done, fault}, 0);
    check(mem_req == 1'b0, "R8 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_read_hit;
    int lat; logic [31:0] pa; logic f; logic [1:0] c; int w0;
    w0 = wr_count;
    do_walk(32'h0040_1ABC, 1'b0, 20'h0, lat, pa, f, c);
    check(pa == 32'hABCD_EABC, "R2 R3 read paddr", pa, 32'hABCD_EABC);
    check(!f && c == 2'd0, "R3 no fault", {30'b0, c}, 0);
    check(lat == 4, "R10 read latency", lat, 4);
    check(wr_count == w0, "R7 no write on read", wr_count - w0, 0);
  endtask

  task automatic t_write_dirty;
    int lat; logic [31:0] pa; logic f; logic [1:0] c; int w0;
    w0 = wr_count;
    do_walk(32'h0040_1004, 1'b1, 20'h0, lat, pa, f, c);
    check(pa == 32'hABCD_E004 && !f, "R3 write paddr", pa, 32'hABCD_E004);
    check(lat == 6, "R10 write-back latency", lat, 6);
    check(wr_count == w0 + 1, "R7 one write-back", wr_count - w0, 1);
    check(last_wa == 32'h0000_1004, "R7 write-back addr", last_wa, 32'h0000_1004);
    check(mem[12'h401] == 32'hABCD_E043, "R7 dirty set", mem[12'h401], 32'hABCD_E043);
    w0 = wr_count;
    do_walk(32'h0040_1008, 1'b1, 20'h0, lat, pa, f, c);
    check(lat == 4 && wr_count == w0, "R7 already dirty no write", wr_count - w0, 0);
    check(pa == 32'hABCD_E008, "R3 dirty page paddr", pa, 32'hABCD_E008);
  endtask

  task automatic t_dir_absent;
    int lat; logic [31:0] pa; logic f; logic [1:0] c;
    do_walk(32'h0080_0123, 1'b0, 20'h0, lat, pa, f, c);
    check(f && c == 2'd1, "R4 dir absent cause", {30'b0, c}, 1);
    check(lat == 2, "R4 R10 no second read", lat, 2);
  endtask

  task automatic t_tbl_absent;
    int lat; logic [31:0] pa; logic f; logic [1:0] c;
    do_walk(32'h0040_2000, 1'b0, 20'h0, lat, pa, f, c);
    check(f && c == 2'd2, "R5 table absent cause", {30'b0, c}, 2);
    check(lat == 4, "R10 table fault latency", lat, 4);
  endtask

  task automatic t_wprot;
    int lat; logic [31:0] pa; logic f; logic [1:0] c; int w0;
    w0 = wr_count;
    do_walk(32'h0040_3010, 1'b1, 20'h0, lat, pa, f, c);
    check(f && c == 2'd3, "R6 table read-only", {30'b0, c}, 3);
    check(wr_count == w0 && mem[12'h403] == 32'h5555_5001, "R6 no write-back", mem[12'h403], 32'h5555_5001);
    do_walk(32'h0040_3010, 1'b0, 20'h0, lat, pa, f, c);
    check(!f && pa == 32'h5555_5010, "R6 read of read-only page", pa, 32'h5555_5010);
    do_walk(32'h00C0_0010, 1'b1, 20'h0, lat, pa, f, c);
    check(f && c == 2'd3 && lat == 2, "R6 directory read-only", {30'b0, c}, 3);
    do_walk(32'h00C0_0010, 1'b0, 20'h0, lat, pa, f, c);
    check(!f && pa == 32'h7777_7010, "R6 R2 read via read-only dir", pa, 32'h7777_7010);
  endtask

  task automatic t_root;
    int lat; logic [31:0] pa; logic f; logic [1:0] c;
    do_walk(32'h0000_0123, 1'b0, 20'h00003, lat, pa, f, c);
    check(!f && pa == 32'h0BEE_F123, "R1 directory root used", pa, 32'h0BEE_F123);
  endtask

  task automatic t_busy;
    int dones;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0040_1ABC; req_write = 1'b0; dir_root = 20'h0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0123; dir_root = 20'h00003;
    @(posedge clk); @(negedge clk);
    check(ready == 1'b0, "R9 busy not ready", 32'(ready), 0);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R9 R10 first result on time", 32'(done), 1);
    check(paddr == 32'hABCD_EABC, "R9 busy request ignored", paddr, 32'hABCD_EABC);
    dones = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R9 single done per request", dones, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    poke(32'h0000_0004, 32'h0000_1003);
    poke(32'h0000_0008, 32'h0000_0000);
    poke(32'h0000_000C, 32'h0000_2001);
    poke(32'h0000_1004, 32'hABCD_E003);
    poke(32'h0000_1008, 32'h1234_5000);
    poke(32'h0000_100C, 32'h5555_5001);
    poke(32'h0000_2000, 32'h7777_7003);
    poke(32'h0000_3000, 32'h0000_4003);
    poke(32'h0000_4000, 32'h0BEE_F003);
    t_read_hit();
    t_busy();
    t_write_dirty();
    t_dir_absent();
    t_tbl_absent();
    t_wprot();
    t_root();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule